// File: doc/BRIEF.md
# Three-Wire Serial Control Slave

This block is the slave end of a three-wire control port. A host drives a serial clock and a mode line and shares one data line with the slave. The mode line frames the traffic: while it is low the host sends a one-byte device selector, and while it is high the bytes that follow are data. Every byte travels least significant bit first, and a byte is complete after eight rising edges of the serial clock.

The selector byte carries a 6-bit device address in its upper six bits and a 2-bit operation code in its two lowest bits. A write sends the register address and then one 16-bit word, upper byte first, and the block presents that word to a register file with a one-cycle write strobe. A read takes two framed transfers. The first is a prepare transfer that carries the register address. The second is a read transfer, and in its data phase the block fetches the word through a one-cycle read strobe and shifts it back to the host. The whole block runs on the system clock. The three serial inputs pass through synchronizer stages, and the edges of the serial clock and of the mode line are found by sampling.

Top module: `tri_wire_ctl_slave`

## Requirements
- R1: After reset the data-line enable, the write strobe and the read strobe are all low.
- R2: In each byte the first bit sampled on a rising serial-clock edge is bit 0, and the byte is complete on the eighth rising edge.
- R3: The block reacts to a selector byte only when bits 7 down to 2 equal the device address, which defaults to 6'b010100. For any other value the transfer causes no strobe and the block never drives the data line.
- R4: Operation code 2'b00 is a write. In the data phase the first byte is the register address, the second byte is bits 15..8 and the third byte is bits 7..0. After the third byte the block raises exactly one write strobe, with that address and that word.
- R5: Operation code 2'b11 is ignored. Nothing is strobed and nothing is driven.
- R6: Operation code 2'b01 is a read-prepare. The first data byte is kept as the register address, and the transfer strobes nothing.
- R7: Operation code 2'b10 is a read. When the mode line rises, the block raises exactly one read strobe using the prepared address. It then shifts out the returned word as two bytes: bits 15..8 first, then bits 7..0, each byte least significant bit first.
- R8: The data-line enable is high only in the data phase of a selected read, and only until all 16 bits have been shifted out.
- R9: Data bytes that follow the third byte of a write are ignored and raise no further write strobe.
- R10: A change on the mode line throws away a partly received byte, so the next byte starts again at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock from the host |
| ser_mode | input | 1 | Framing line: low for the selector phase, high for the data phase |
| ser_din | input | 1 | Data line as seen at the pad |
| ser_dout | output | 1 | Value driven onto the data line |
| ser_doe | output | 1 | Enable of the data-line driver |
| rf_addr | output | 8 | Register address |
| rf_wdata | output | 16 | Write word |
| rf_we | output | 1 | One-cycle write strobe |
| rf_re | output | 1 | One-cycle read strobe |
| rf_rdata | input | 16 | Read word; must be valid in the cycle after rf_re |

## Verification
A wrong bit or byte count shows up as soon as the third data byte of a write: the word on rf_wdata is shifted or has its halves swapped, or the strobe fires on the wrong byte. A wrong address decode shows in the device sweep as a write strobe for a foreign address, or as a missing strobe for the own address, during that same transfer. A stale operation state or a bad read counter shows within one read as an unexpected strobe count, a corrupted returned word, or a driver enable that is still high after the sixteenth bit.

// File: rtl/tws_pkg.sv
package tws_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_WRITE = 2'd1,
    OP_PREP = 2'd2,
    OP_READ = 2'd3
  } tws_op_e;

  localparam logic [1:0] CODE_WR   = 2'b00;
  localparam logic [1:0] CODE_PREP = 2'b01;
  localparam logic [1:0] CODE_RD   = 2'b10;
endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES*W-1:0] chain_q, chain_d;

  always_comb chain_d = {chain_q[(STAGES-1)*W-1:0], d_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES*W-1 -: W];
endmodule

// File: rtl/tws_rx.sv
module tws_rx #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_stb,
  input  logic          restart,
  input  logic          din,
  output logic          byte_vld,
  output logic [BW-1:0] byte_o
);
  localparam int CW = $clog2(BW);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [BW-1:0] sh_q, sh_d;
  logic          vld_q, vld_d;

  always_comb begin
    cnt_d = cnt_q;
    sh_d  = sh_q;
    vld_d = 1'b0;
    if (restart) begin
      cnt_d = '0;
    end else if (bit_stb) begin
      sh_d = {din, sh_q[BW-1:1]};
      if (cnt_q == CW'(BW-1)) begin
        cnt_d = '0;
        vld_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
      vld_q <= vld_d;
    end
  end

  assign byte_vld = vld_q;
  assign byte_o   = sh_q;

  // R2
  rx_vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);
  // R10
  rx_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0) && !vld_q);
endmodule

// File: rtl/tws_tx.sv
module tws_tx #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] ld_data,
  input  logic          shift,
  input  logic          clear,
  output logic          bit_o,
  output logic          active_o
);
  localparam int HALF = DW / 2;
  localparam int CW   = $clog2(DW + 1);

  logic [DW-1:0] sh_q, sh_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (clear) begin
      cnt_d = '0;
    end else if (load) begin
      sh_d  = {ld_data[HALF-1:0], ld_data[DW-1:HALF]};
      cnt_d = CW'(DW);
    end else if (shift && cnt_q != '0) begin
      sh_d  = {1'b0, sh_q[DW-1:1]};
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  assign bit_o    = sh_q[0];
  assign active_o = (cnt_q != '0);

  // R8
  tx_count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(load) |-> cnt_q <= $past(cnt_q));
endmodule

// File: rtl/tri_wire_ctl_slave.sv
module tri_wire_ctl_slave #(
  parameter logic [5:0] DEV_ADDR    = 6'b010100,
  parameter int         SYNC_STAGES = 2,
  parameter int         BW          = 8,
  parameter int         DW          = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ser_clk,
  input  logic          ser_mode,
  input  logic          ser_din,
  output logic          ser_dout,
  output logic          ser_doe,
  output logic [BW-1:0] rf_addr,
  output logic [DW-1:0] rf_wdata,
  output logic          rf_we,
  output logic          rf_re,
  input  logic [DW-1:0] rf_rdata
);
  import tws_pkg::*;

  localparam int HALF = DW / 2;

  logic [2:0]    sync_q;
  logic          sclk_prev_q, mode_prev_q;
  logic          sclk_rise, mode_rise, mode_fall, mode_lvl, din_s;
  logic          byte_vld;
  logic [BW-1:0] rx_byte;
  logic          tx_bit, tx_active;

  tws_op_e       op_q, op_d;
  logic [1:0]    bcnt_q, bcnt_d;
  logic [BW-1:0] addr_q, addr_d;
  logic [HALF-1:0] hi_q, hi_d;
  logic [DW-1:0] wdat_q, wdat_d;
  logic          we_q, we_d, re_q, re_d, ld_q;

  tws_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({ser_din, ser_mode, ser_clk}), .q_o(sync_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev_q <= 1'b0;
      mode_prev_q <= 1'b0;
    end else begin
      sclk_prev_q <= sync_q[0];
      mode_prev_q <= sync_q[1];
    end
  end

  assign sclk_rise = sync_q[0] & ~sclk_prev_q;
  assign mode_rise = sync_q[1] & ~mode_prev_q;
  assign mode_fall = ~sync_q[1] & mode_prev_q;
  assign mode_lvl  = sync_q[1];
  assign din_s     = sync_q[2];

  tws_rx #(.BW(BW)) u_rx (
    .clk(clk), .rst_n(rst_n), .bit_stb(sclk_rise),
    .restart(mode_rise | mode_fall), .din(din_s),
    .byte_vld(byte_vld), .byte_o(rx_byte)
  );

  // next-state logic
  always_comb begin
    op_d   = op_q;
    bcnt_d = bcnt_q;
    addr_d = addr_q;
    hi_d   = hi_q;
    wdat_d = wdat_q;
    we_d   = 1'b0;
    re_d   = 1'b0;
    if (mode_fall) begin
      op_d   = OP_IDLE;
      bcnt_d = '0;
    end else if (mode_rise) begin
      bcnt_d = '0;
      if (op_q == OP_READ) re_d = 1'b1;
    end else if (byte_vld) begin
      if (!mode_lvl) begin
        op_d = OP_IDLE;
        if (rx_byte[BW-1:2] == DEV_ADDR) begin
          case (rx_byte[1:0])
            CODE_WR:   op_d = OP_WRITE;
            CODE_PREP: op_d = OP_PREP;
            CODE_RD:   op_d = OP_READ;
            default:   op_d = OP_IDLE;
          endcase
        end
      end else begin
        if (bcnt_q != 2'd3) bcnt_d = bcnt_q + 2'd1;
        case (op_q)
          OP_WRITE: begin
            case (bcnt_q)
              2'd0: addr_d = rx_byte;
              2'd1: hi_d   = rx_byte[HALF-1:0];
              2'd2: begin
                wdat_d = {hi_q, rx_byte[HALF-1:0]};
                we_d   = 1'b1;
              end
              default: ;
            endcase
          end
          OP_PREP: if (bcnt_q == 2'd0) addr_d = rx_byte;
          default: ;
        endcase
      end
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_IDLE;
      bcnt_q <= '0;
      addr_q <= '0;
      hi_q   <= '0;
      wdat_q <= '0;
      we_q   <= 1'b0;
      re_q   <= 1'b0;
      ld_q   <= 1'b0;
    end else begin
      op_q   <= op_d;
      bcnt_q <= bcnt_d;
      addr_q <= addr_d;
      hi_q   <= hi_d;
      wdat_q <= wdat_d;
      we_q   <= we_d;
      re_q   <= re_d;
      ld_q   <= re_q;
    end
  end

  tws_tx #(.DW(DW)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(ld_q), .ld_data(rf_rdata),
    .shift(sclk_rise & mode_lvl), .clear(mode_fall),
    .bit_o(tx_bit), .active_o(tx_active)
  );

  assign ser_doe  = tx_active & mode_lvl & (op_q == OP_READ);
  assign ser_dout = ser_doe & tx_bit;
  assign rf_addr  = addr_q;
  assign rf_wdata = wdat_q;
  assign rf_we    = we_q;
  assign rf_re    = re_q;

  // R4
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> !rf_we);
  // R4
  we_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> $past(byte_vld) && $past(mode_lvl));
  // R7
  re_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_re |=> !rf_re);
  // R7
  re_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_re |-> $past(mode_rise));
  // R8
  doe_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_doe |-> !rf_we && mode_lvl);
endmodule

// File: tb/sim_tri_wire_ctl_slave.sv
module sim_tri_wire_ctl_slave;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_mode = 1'b0, ser_din = 1'b0;
  logic ser_dout, ser_doe, rf_we, rf_re;
  logic [7:0]  rf_addr;
  logic [15:0] rf_wdata, rf_rdata;

  int total = 0, bad = 0;
  int we_cnt = 0, re_cnt = 0, doe_cyc = 0;
  logic [7:0]  last_wa, last_ra;
  logic [15:0] last_wd;
  bit done = 0;

  always #10 clk = ~clk;

  tri_wire_ctl_slave u0 (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_mode(ser_mode),
    .ser_din(ser_din), .ser_dout(ser_dout), .ser_doe(ser_doe),
    .rf_addr(rf_addr), .rf_wdata(rf_wdata), .rf_we(rf_we), .rf_re(rf_re),
    .rf_rdata(rf_rdata)
  );

  function automatic logic [15:0] model_rd(logic [7:0] a);
    return {a ^ 8'h3C, ~a};
  endfunction
  assign rf_rdata = model_rd(rf_addr);

  always @(posedge clk) begin
    if (rf_we) begin we_cnt++; last_wa = rf_addr; last_wd = rf_wdata; end
    if (rf_re) begin re_cnt++; last_ra = rf_addr; end
    if (ser_doe) doe_cyc++;
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(logic m);
    ser_mode = m;
    tick(6);
  endtask

  task automatic send_bit(logic b);
    ser_din = b; tick(4); ser_clk = 1'b1; tick(4); ser_clk = 1'b0;
  endtask

  task automatic send_byte(logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
  endtask

  task automatic recv_byte(output logic [7:0] v);
    for (int i = 0; i < 8; i++) begin
      tick(4); v[i] = ser_dout; ser_clk = 1'b1; tick(4); ser_clk = 1'b0;
    end
  endtask

  task automatic do_write(logic [7:0] sel, logic [7:0] ra, logic [15:0] d);
    set_mode(1'b0); send_byte(sel);
    set_mode(1'b1); send_byte(ra); send_byte(d[15:8]); send_byte(d[7:0]);
    tick(4); set_mode(1'b0);
  endtask

  task automatic do_read(logic [7:0] ra);
    int r0;
    logic [7:0] b0, b1;
    set_mode(1'b0); send_byte(8'h51);
    set_mode(1'b1); send_byte(ra);
    set_mode(1'b0); send_byte(8'h52);
    r0 = re_cnt;
    set_mode(1'b1);
    chk(ser_doe === 1'b1, "R8 enable in read data phase", 32'(ser_doe), 1);
    chk(re_cnt == r0 + 1, "R7 one read strobe", 32'(re_cnt - r0), 1);
    chk(last_ra == ra, "R6 prepared address used", 32'(last_ra), 32'(ra));
    recv_byte(b0); recv_byte(b1);
    chk({b0, b1} == model_rd(ra), "R7 returned word order", {b0, b1}, 32'(model_rd(ra)));
    tick(4);
    chk(ser_doe === 1'b0, "R8 enable drops after 16 bits", 32'(ser_doe), 0);
    set_mode(1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int w0, d0, r0;
    tick(3);
    chk(ser_doe === 1'b0 && rf_we === 1'b0 && rf_re === 1'b0, "R1 reset outputs",
        {ser_doe, rf_we, rf_re}, 0);
    rst_n = 1'b1;
    tick(4);

    // R2 R4: write sweep
    for (int a = 0; a < 16; a++) begin
      logic [7:0] ra = 8'(a * 17);
      logic [15:0] d = 16'(a * 4099 + 7);
      w0 = we_cnt;
      do_write(8'h50, ra, d);
      chk(we_cnt == w0 + 1, "R4 one write strobe", 32'(we_cnt - w0), 1);
      chk(last_wa == ra, "R4 write address", 32'(last_wa), 32'(ra));
      chk(last_wd == d, "R2 write word bit order", 32'(last_wd), 32'(d));
    end

    // R9: trailing bytes
    w0 = we_cnt;
    set_mode(1'b0); send_byte(8'h50);
    set_mode(1'b1); send_byte(8'h21); send_byte(8'hBE); send_byte(8'hEF);
    send_byte(8'h11); send_byte(8'h22); tick(4); set_mode(1'b0);
    chk(we_cnt == w0 + 1, "R9 extra bytes ignored", 32'(we_cnt - w0), 1);
    chk(last_wd == 16'hBEEF, "R9 word kept", 32'(last_wd), 32'hBEEF);

    // R3: device address sweep
    for (int dv = 0; dv < 64; dv++) begin
      logic [5:0] dev = 6'(dv);
      w0 = we_cnt; d0 = doe_cyc;
      do_write({dev, 2'b00}, 8'h77, 16'h1234);
      if (dev == 6'b010100)
        chk(we_cnt == w0 + 1, "R3 own address accepted", 32'(we_cnt - w0), 1);
      else
        chk(we_cnt == w0 && doe_cyc == d0, "R3 foreign address ignored",
            32'(we_cnt - w0), 0);
    end

    // R5: code 11 ignored
    w0 = we_cnt; r0 = re_cnt; d0 = doe_cyc;
    set_mode(1'b0); send_byte(8'h53);
    set_mode(1'b1); send_byte(8'h44); send_byte(8'h55); send_byte(8'h66);
    tick(4); set_mode(1'b0);
    chk(we_cnt == w0 && re_cnt == r0 && doe_cyc == d0, "R5 code 11 ignored",
        32'(we_cnt - w0 + re_cnt - r0 + doe_cyc - d0), 0);

    // R6: prepare alone strobes nothing
    w0 = we_cnt; r0 = re_cnt;
    set_mode(1'b0); send_byte(8'h51);
    set_mode(1'b1); send_byte(8'h9A); tick(4); set_mode(1'b0);
    chk(we_cnt == w0 && re_cnt == r0, "R6 prepare has no strobe",
        32'(we_cnt - w0 + re_cnt - r0), 0);
    chk(rf_addr == 8'h9A, "R6 prepared address", 32'(rf_addr), 32'h9A);

    // R7 R8: read sweep
    for (int r = 0; r < 32; r++) do_read(8'(r * 8 + 5));

    // R10: partial byte discarded at mode change
    w0 = we_cnt;
    set_mode(1'b1); send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
    set_mode(1'b0); send_bit(1'b1); send_bit(1'b0);
    set_mode(1'b1); set_mode(1'b0); send_byte(8'h50);
    set_mode(1'b1); send_byte(8'hC3); send_byte(8'h5A); send_byte(8'hA5);
    tick(4); set_mode(1'b0);
    chk(we_cnt == w0 + 1, "R10 restart count", 32'(we_cnt - w0), 1);
    chk(last_wa == 8'hC3 && last_wd == 16'h5AA5, "R10 word after restart",
        {last_wa, last_wd}, 32'hC35AA5);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule